// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Access Sequencer

This block converts a single load or store in a flash address window into a complete SPI flash transaction on one of several slaves. Each slave has its own control word, which selects how an access is framed: read, fast read, write or raw user pass-through. The control word also holds the command byte, the fast-read dummy length and a manual stop bit that drives the slave's chip select. A shared global word holds a write-enable bit and a 4-byte address bit for each slave.

A bus-side request carries the slave number, direction, address, length (1 to 4 bytes) and store data. `acc_busy` stays high until every SPI byte has been shifted. The completion cycle shows `acc_done`, together with the little-endian read data and an error flag. On the flash side the block issues one byte at a time to an external byte shifter and waits for that byte's completion before it issues the next. It also drives one active-low chip select per slave.

Top module: `spi_flash_seq`

## Requirements
- R1: The access mode is bits [1:0] of the slave's control word: 0 = read, 1 = fast read, 2 = write, 3 = user.
- R2: The command byte is control bits [23:16]. In read mode a zero command is replaced by 0x03.
- R3: A framed access ends at once with `acc_err` = 1, sends no byte and leaves the chip selects unchanged in any of these cases: a zero command in fast-read or write mode, a store in read or fast-read mode, or a load in write mode.
- R4: A framed access (modes 0 to 2) proceeds in this order: chip select low, command byte, address bytes most significant first, optional dummy bytes, data bytes, chip select high. The chip select is high again by the completion cycle.
- R5: The address is 4 bytes when global bit [i] is set for slave i. Otherwise it is 3 bytes, taken from address bits [23:0].
- R6: In fast-read mode only, 8 × {control bit 14, control bits [7:6]} dummy bytes of value 0xFF follow the address.
- R7: `acc_len` holds the byte count minus one. Data bytes go out and come back least significant byte first. Load data bytes are sent as 0x00.
- R8: In user mode only data bytes are transferred, and the chip select is left as control bit 2 sets it.
- R9: Control bit 2 is the stop bit. `cs_n[i]` follows bit 2 of slave i's control word starting in the cycle after that word is written.
- R10: A store to slave i while global bit [16+i] is clear completes with no error and sends no byte.
- R11: The flash address is the access address masked to the low SEG_LOG2 bits.
- R12: `acc_busy` rises the cycle after an accepted request and falls after the single `acc_done` cycle. A request made while busy is ignored. At most one shifter byte is outstanding at any time.
- R13: If a request is accepted in the same cycle as a write to that slave's control word, the access uses the old word. The framed access still drives the chip select low, whatever stop bit the write carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Write strobe for a slave control word |
| ctrl_sel | input | CSW | Slave whose control word is written |
| ctrl_wdata | input | 32 | New control word |
| glob_we | input | 1 | Write strobe for the global word |
| glob_wdata | input | 32 | New global word (bit i: 4-byte address, bit 16+i: write enable) |
| acc_req | input | 1 | Access request, sampled while idle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_cs | input | CSW | Target slave |
| acc_addr | input | 32 | Access address |
| acc_len | input | 2 | Byte count minus one |
| acc_wdata | input | 32 | Store data, little-endian |
| acc_busy | output | 1 | Access in progress |
| acc_done | output | 1 | Completion cycle |
| acc_err | output | 1 | Error flag, valid with `acc_done` |
| acc_rdata | output | 32 | Load data, valid with `acc_done` |
| sh_start | output | 1 | Shift one byte |
| sh_tx | output | 8 | Byte to send, valid with `sh_start` |
| sh_done | input | 1 | Shifter finished the outstanding byte |
| sh_rx | input | 8 | Byte received, valid with `sh_done` |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
Two functions can fall in the same cycle: acceptance of a request and a write to that slave's control word. The bench provokes this by driving both strobes together. The write turns the slave from read into fast read and sets the stop bit. The scoreboard must then see a read-mode frame with no dummies and a low chip select. The following access must show the new fast-read dummies, which proves the write itself took effect.

// File: rtl/spi_flash_seq.sv
module spi_flash_seq #(
  parameter int NUM_CS   = 2,
  parameter int SEG_LOG2 = 20,
  localparam int CSW     = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CSW-1:0]    ctrl_sel,
  input  logic [31:0]       ctrl_wdata,
  input  logic              glob_we,
  input  logic [31:0]       glob_wdata,
  input  logic              acc_req,
  input  logic              acc_write,
  input  logic [CSW-1:0]    acc_cs,
  input  logic [31:0]       acc_addr,
  input  logic [1:0]        acc_len,
  input  logic [31:0]       acc_wdata,
  output logic              acc_busy,
  output logic              acc_done,
  output logic              acc_err,
  output logic [31:0]       acc_rdata,
  output logic              sh_start,
  output logic [7:0]        sh_tx,
  input  logic              sh_done,
  input  logic [7:0]        sh_rx,
  output logic [NUM_CS-1:0] cs_n
);
  localparam logic [31:0] SEG_MASK = (32'h1 << SEG_LOG2) - 32'h1;
  localparam logic [1:0] M_READ = 2'd0, M_FAST = 2'd1, M_WRITE = 2'd2, M_USER = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_FIN} state_t;

  state_t          state;
  logic [31:0]     ctrl_q [NUM_CS];
  logic [31:0]     glob_q;
  logic [CSW-1:0]  cur_cs;
  logic [1:0]      cur_mode;
  logic [7:0]      cur_cmd;
  logic [31:0]     cur_addr, cur_wdata;
  logic            cur_write, cur_four, wait_q, err_q;
  logic [1:0]      cur_len;
  logic [5:0]      cur_dummy, cnt;
  logic [31:0]     rdata_q;

  wire [31:0]       sel_word = ctrl_q[acc_cs];
  wire [1:0]        sel_mode = sel_word[1:0];
  wire [7:0]        sel_cmd  = sel_word[23:16];
  wire [NUM_CS-1:0] wen_vec  = glob_q[16 +: NUM_CS];
  wire [NUM_CS-1:0] four_vec = glob_q[NUM_CS-1:0];
  wire accept   = acc_req && (state == S_IDLE);
  wire drop     = acc_write && !wen_vec[acc_cs];
  wire bad      = !drop && (sel_mode != M_USER) &&
                  ((sel_cmd == 8'h00 && sel_mode != M_READ) || (acc_write != (sel_mode == M_WRITE)));
  wire byte_done = wait_q && sh_done;
  wire [31:0] addr_sh = cur_addr  >> {cnt[1:0], 3'b000};
  wire [31:0] wd_sh   = cur_wdata >> {cnt[1:0], 3'b000};

  assign acc_busy  = (state != S_IDLE);
  assign acc_done  = (state == S_FIN);
  assign acc_err   = err_q;
  assign acc_rdata = rdata_q;
  assign sh_start  = (state == S_CMD || state == S_ADDR || state == S_DUMMY || state == S_DATA) && !wait_q;

  always_comb begin
    case (state)
      S_CMD:   sh_tx = cur_cmd;
      S_ADDR:  sh_tx = addr_sh[7:0];
      S_DUMMY: sh_tx = 8'hFF;
      S_DATA:  sh_tx = cur_write ? wd_sh[7:0] : 8'h00;
      default: sh_tx = 8'h00;
    endcase
    for (int i = 0; i < NUM_CS; i++) cs_n[i] = ctrl_q[i][2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      for (int i = 0; i < NUM_CS; i++) ctrl_q[i] <= 32'h0000_0004;
      glob_q <= '0;
      cur_cs <= '0; cur_mode <= '0; cur_cmd <= '0; cur_addr <= '0; cur_wdata <= '0;
      cur_write <= 1'b0; cur_four <= 1'b0; cur_len <= '0; cur_dummy <= '0;
      cnt <= '0; wait_q <= 1'b0; err_q <= 1'b0; rdata_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q[ctrl_sel] <= ctrl_wdata;
      if (glob_we) glob_q <= glob_wdata;
      if (sh_start) wait_q <= 1'b1;
      else if (byte_done) wait_q <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          cur_cs    <= acc_cs;
          cur_mode  <= sel_mode;
          cur_cmd   <= (sel_cmd == 8'h00 && sel_mode == M_READ) ? 8'h03 : sel_cmd;
          cur_addr  <= acc_addr & SEG_MASK;
          cur_wdata <= acc_wdata;
          cur_write <= acc_write;
          cur_four  <= four_vec[acc_cs];
          cur_len   <= acc_len;
          cur_dummy <= {sel_word[14], sel_word[7:6], 3'b000};
          rdata_q   <= '0;
          err_q     <= bad;
          cnt       <= '0;
          if (drop || bad)              state <= S_FIN;
          else if (sel_mode == M_USER)  state <= S_DATA;
          else begin
            state <= S_CMD;
            ctrl_q[acc_cs][2] <= 1'b0;
          end
        end
        S_CMD: if (byte_done) begin
          state <= S_ADDR;
          cnt   <= cur_four ? 6'd3 : 6'd2;
        end
        S_ADDR: if (byte_done) begin
          if (cnt != 6'd0) cnt <= cnt - 6'd1;
          else if (cur_mode == M_FAST && cur_dummy != 6'd0) begin
            state <= S_DUMMY;
            cnt   <= cur_dummy - 6'd1;
          end else state <= S_DATA;
        end
        S_DUMMY: if (byte_done) begin
          if (cnt != 6'd0) cnt <= cnt - 6'd1;
          else state <= S_DATA;
        end
        S_DATA: if (byte_done) begin
          if (!cur_write) rdata_q[{cnt[1:0], 3'b000} +: 8] <= sh_rx;
          if (cnt[1:0] == cur_len) begin
            state <= S_FIN;
            if (cur_mode != M_USER) ctrl_q[cur_cs][2] <= 1'b1;
          end else cnt <= cnt + 6'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_flash_seq_chk.sv
module spi_flash_seq_chk #(
  parameter int NUM_CS = 2,
  localparam int CSW   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_req,
  input logic              acc_write,
  input logic [CSW-1:0]    acc_cs,
  input logic              acc_busy,
  input logic              acc_done,
  input logic              sh_start,
  input logic              ctrl_we,
  input logic [CSW-1:0]    ctrl_sel,
  input logic [31:0]       ctrl_wdata,
  input logic [NUM_CS-1:0] cs_n,
  input logic [31:0]       glob_q,
  input logic [1:0]        cur_mode,
  input logic [CSW-1:0]    cur_cs
);
  wire [NUM_CS-1:0] wen = glob_q[16 +: NUM_CS];

  AST_ONE_BYTE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n) sh_start |=> !sh_start); // R12
  AST_START_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) sh_start |-> acc_busy); // R12
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) acc_done |=> !acc_busy); // R12
  AST_DROP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_busy && acc_write && !wen[acc_cs]) |=> (acc_done && !sh_start)); // R10
  AST_FRAMED_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_start && cur_mode != 2'd3) |-> !cs_n[cur_cs]); // R4
  AST_STOP_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && !acc_busy && !acc_req) |=> (cs_n[$past(ctrl_sel)] == $past(ctrl_wdata[2]))); // R9
endmodule

bind spi_flash_seq spi_flash_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_write(acc_write), .acc_cs(acc_cs),
  .acc_busy(acc_busy), .acc_done(acc_done), .sh_start(sh_start), .ctrl_we(ctrl_we),
  .ctrl_sel(ctrl_sel), .ctrl_wdata(ctrl_wdata), .cs_n(cs_n), .glob_q(glob_q),
  .cur_mode(cur_mode), .cur_cs(cur_cs)
);

// File: tb/tb_spi_flash_seq.sv
module tb_spi_flash_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 0, glob_we = 0, acc_req = 0, acc_write = 0;
  logic [0:0] ctrl_sel = '0, acc_cs = '0;
  logic [31:0] ctrl_wdata = '0, glob_wdata = '0, acc_addr = '0, acc_wdata = '0;
  logic [1:0] acc_len = '0;
  logic acc_busy, acc_done, acc_err, sh_start, sh_done = 1'b0;
  logic [31:0] acc_rdata;
  logic [7:0] sh_tx, sh_rx = '0;
  logic [1:0] cs_n;

  spi_flash_seq #(.NUM_CS(2), .SEG_LOG2(20)) dut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0, nbytes = 0, rx_idx = 0, dly = 0, cyc = 0;
  bit ended = 0;
  logic [9:0] expq[$];
  logic [31:0] sh_ctrl [2] = '{32'h4, 32'h4};
  logic [31:0] sh_glob = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", req, act, exp); end
  endtask

  function automatic int push(input logic [7:0] b, input logic [1:0] csn);
    expq.push_back({csn, b});
    nbytes++;
    return nbytes - 1;
  endfunction

  // flash model: answers each byte two cycles later
  always @(negedge clk) begin
    sh_done <= 1'b0;
    if (dly > 0) begin
      dly--;
      if (dly == 0) begin sh_done <= 1'b1; sh_rx <= 8'(rx_idx) ^ 8'h5A; rx_idx++; end
    end else if (rst_n && sh_start) dly = 2;
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && sh_start) begin
    if (expq.size() == 0) chk(0, "R4/R3/R10 unexpected byte", {22'd0, cs_n, sh_tx}, 32'hFFFF_FFFF);
    else begin
      logic [9:0] e;
      e = expq.pop_front();
      chk({cs_n, sh_tx} == e, "R4 byte/cs stream", {22'd0, cs_n, sh_tx}, {22'd0, e});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000 && !ended) begin
      ended = 1; checks++; fails++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wr_ctrl(input int cs, input logic [31:0] w);
    @(negedge clk); ctrl_we = 1; ctrl_sel = 1'(cs); ctrl_wdata = w;
    @(negedge clk); ctrl_we = 0; sh_ctrl[cs] = w;
    chk(cs_n[cs] == w[2], "R9 stop bit to cs_n", {31'd0, cs_n[cs]}, {31'd0, w[2]});
  endtask

  task automatic wr_glob(input logic [31:0] w);
    @(negedge clk); glob_we = 1; glob_wdata = w;
    @(negedge clk); glob_we = 0; sh_glob = w;
  endtask

  task automatic do_acc(input int cs, input bit wr, input logic [31:0] addr, input logic [1:0] len,
                        input logic [31:0] wd, input bit cw, input logic [31:0] cw_word,
                        input bit exp_err, input string tag);
    logic [31:0] w, a, exp_rd;
    logic [1:0] mode, csn_fr, csn_now, csn_end;
    logic [7:0] cmd;
    bit drop, bad, fr;
    int nd, idx, n;
    w = sh_ctrl[cs]; mode = w[1:0]; cmd = w[23:16];
    fr = (mode != 2'd3);
    drop = wr && !sh_glob[16+cs];
    bad = !drop && fr && ((cmd == 0 && mode != 0) || (wr != (mode == 2'd2)));
    if (mode == 0 && cmd == 0) cmd = 8'h03;
    csn_now = {sh_ctrl[1][2], sh_ctrl[0][2]};
    csn_fr = 2'b11 & ~(2'b01 << cs);
    a = addr & 32'h000F_FFFF;
    exp_rd = '0;
    csn_end = csn_now;
    if (!drop && !bad) begin
      if (fr) begin
        idx = push(cmd, csn_fr);
        n = sh_glob[cs] ? 4 : 3;
        for (int k = n - 1; k >= 0; k--) idx = push(a[8*k +: 8], csn_fr);
        nd = (mode == 1) ? 8 * {w[14], w[7:6]} : 0;
        for (int k = 0; k < nd; k++) idx = push(8'hFF, csn_fr);
        csn_end = 2'b11;
      end
      for (int k = 0; k <= int'(len); k++) begin
        idx = push(wr ? wd[8*k +: 8] : 8'h00, fr ? csn_fr : csn_now);
        if (!wr) exp_rd[8*k +: 8] = 8'(idx) ^ 8'h5A;
      end
    end
    @(negedge clk);
    acc_req = 1; acc_write = wr; acc_cs = 1'(cs); acc_addr = addr; acc_len = len; acc_wdata = wd;
    if (cw) begin ctrl_we = 1; ctrl_sel = 1'(cs); ctrl_wdata = cw_word; end
    @(negedge clk);
    acc_req = 0; ctrl_we = 0;
    if (cw) sh_ctrl[cs] = cw_word;
    chk(acc_busy, {"R12 busy after accept ", tag}, {31'd0, acc_busy}, 32'd1);
    while (!acc_done) @(negedge clk);
    chk(acc_err == exp_err, {"R3 error flag ", tag}, {31'd0, acc_err}, {31'd0, exp_err});
    if (!wr && !exp_err) chk(acc_rdata == exp_rd, {"R7 read data ", tag}, acc_rdata, exp_rd);
    chk(expq.size() == 0, {"R4 stream complete ", tag}, expq.size(), 0);
    chk(cs_n == csn_end, {"R4 cs at completion ", tag}, {30'd0, cs_n}, {30'd0, csn_end});
    @(negedge clk);
    chk(!acc_busy, {"R12 idle after done ", tag}, {31'd0, acc_busy}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n == 2'b11 && !acc_busy && !sh_start, "reset state", {29'd0, acc_busy, cs_n}, 32'd3);
    // R1 R2 R11: read mode, zero command defaults to 0x03, 3-byte masked address
    do_acc(0, 0, 32'hABF1_2345, 2'd3, 0, 0, 0, 0, "R1 R2 R11 read default cmd");
    // R5: 4-byte address on slave 1
    wr_glob(32'h0000_0002);
    wr_ctrl(1, 32'h0013_0004);
    do_acc(1, 0, 32'hABF1_2345, 2'd0, 0, 0, 0, 0, "R5 four-byte");
    // R6: fast read dummies 8 and 40
    wr_ctrl(0, 32'h000B_0045);
    do_acc(0, 0, 32'h0000_0100, 2'd1, 0, 0, 0, 0, "R6 fast 8 dummies");
    wr_ctrl(0, 32'h000B_4045);
    do_acc(0, 0, 32'h0000_0200, 2'd2, 0, 0, 0, 0, "R6 fast 40 dummies");
    // R10: write without enable dropped
    wr_ctrl(0, 32'h0002_0006);
    do_acc(0, 1, 32'h0000_0010, 2'd3, 32'hDEAD_BEEF, 0, 0, 0, "R10 dropped store");
    wr_glob(32'h0003_0002);
    do_acc(0, 1, 32'h0000_0010, 2'd2, 32'h00C0_FFEE, 0, 0, 0, "R7 framed store");
    // R3: errors
    do_acc(0, 0, 32'h0000_0010, 2'd0, 0, 0, 0, 1, "R3 load in write mode");
    wr_ctrl(0, 32'h0000_0045);
    do_acc(0, 0, 32'h0000_0010, 2'd0, 0, 0, 0, 1, "R3 zero fast cmd");
    // R8 R9: user mode, manual chip select
    wr_ctrl(1, 32'h0000_0007);
    wr_ctrl(1, 32'h0000_0003);
    do_acc(1, 1, 32'h0000_0000, 2'd1, 32'h0000_9F05, 0, 0, 0, "R8 user store");
    do_acc(1, 0, 32'h0000_0000, 2'd1, 0, 0, 0, 0, "R8 user load");
    wr_ctrl(1, 32'h0000_0007);
    // R12: request while busy is ignored
    wr_ctrl(0, 32'h0000_0004);
    fork
      do_acc(0, 0, 32'h0000_0040, 2'd0, 0, 0, 0, 0, "R12 busy request");
      begin
        repeat (3) @(negedge clk);
        acc_req = 1; acc_cs = 1'b1; @(negedge clk); acc_req = 0;
      end
    join
    // R13: same-cycle accept and control write
    do_acc(0, 0, 32'h0000_0080, 2'd0, 0, 1, 32'h000B_0045, 0, "R13 same-cycle old word");
    do_acc(0, 0, 32'h0000_0084, 2'd0, 0, 0, 0, 0, "R13 new word applied");
    repeat (5) @(negedge clk);
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule